// File: doc/BRIEF.md
# Segment Privilege Check Unit

This block judges a single segment access against the protection-level rules. Each request carries the level of the running code, the level requested through the selector, the level recorded in the target descriptor, the kind of access (data reference or code transfer) and a real-mode flag. One clock after the request strobe, the block gives a registered verdict: exactly one of grant or fault is high.

The decision first works out an effective level. This is the less privileged of the running code's level and the selector's requested level, which means it is the numerically larger of the two. A data reference is then compared against the descriptor using that effective level. A code transfer compares the descriptor level with the running code's level. In real mode the running level counts as 0. The effective level is also output so that later checks can use it.

Descriptor fetch, limit checks, segment type checks and paging are handled elsewhere. Levels are `LVL_W` bits wide (default 2, values 0..3, where 0 is the most privileged). A parameter chooses between two internal forms of the maximum logic.

Top module: `seg_priv_check`

## Requirements
- R1: While reset is held and in the first cycle after it, `grant_o`, `fault_o` and `epl_o` are all 0.
- R2: When `req_valid_i` is low at a clock edge, `grant_o` and `fault_o` are low and `epl_o` is 0 after that edge, whatever the other inputs are.
- R3: One cycle after a request, `epl_o` equals the numerically larger of `rpl_i` and the running level. A requested level of 3 always gives 3, and a requested level of 0 gives the running level.
- R4: When `real_mode_i` is 1, the running level is taken as 0 for every purpose and `cur_lvl_i` has no effect on the outputs.
- R5: For a data reference (`kind_i` = 0), `grant_o` is high one cycle later when the effective level is at most `dpl_i`. Otherwise `fault_o` is high.
- R6: For a code transfer (`kind_i` = 1), `grant_o` is high one cycle later when `dpl_i` is at most the running level. Otherwise `fault_o` is high. `rpl_i` does not affect this verdict.
- R7: One cycle after every request, exactly one of `grant_o` and `fault_o` is high. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_n_i | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request strobe, one check per high cycle |
| real_mode_i | input | 1 | 1 = real mode, running level forced to 0 |
| cur_lvl_i | input | LVL_W | Level of the running code |
| rpl_i | input | LVL_W | Level requested by the selector |
| dpl_i | input | LVL_W | Level stored in the descriptor |
| kind_i | input | 1 | 0 = data reference, 1 = code transfer |
| epl_o | output | LVL_W | Registered effective level, 0 when idle |
| grant_o | output | 1 | Registered access granted |
| fault_o | output | 1 | Registered protection fault |

## Verification
Directed cases probe each end of the effective-level rule. A requested level of 3 against a running level of 0 exposes a design that takes the minimum instead of the maximum. A requested level of 0 against a running level of 2 exposes a design that ignores the running level. Code transfers with a large requested level and a small descriptor level show whether the requested level wrongly enters the code verdict. Real-mode requests with a running level of 3 show whether the forcing to 0 is applied. Idle cycles with inputs that would otherwise fault confirm that the strobe gates the outputs. Several thousand seeded random requests then cover every level combination for both access kinds.

// File: rtl/seg_priv_pkg.sv
package seg_priv_pkg;

   typedef enum logic {
      ACC_DATA = 1'b0,
      ACC_CODE = 1'b1
   } acc_kind_e;

   localparam int unsigned LVL_W_MIN = 1;
   localparam int unsigned LVL_W_MAX = 4;

endpackage

// File: rtl/seg_priv_cpl_sel.sv
module seg_priv_cpl_sel #(
   parameter int unsigned LVL_W = 2
) (
   input  logic             real_mode_i,
   input  logic [LVL_W-1:0] cur_lvl_i,
   output logic [LVL_W-1:0] cpl_o
);

   always_comb begin
      if (real_mode_i) cpl_o = '0;
      else             cpl_o = cur_lvl_i;
   end

endmodule

// File: rtl/seg_priv_epl.sv
module seg_priv_epl #(
   parameter int unsigned LVL_W      = 2,
   parameter bit          USE_THERMO = 1'b0
) (
   input  logic [LVL_W-1:0] a_i,
   input  logic [LVL_W-1:0] b_i,
   output logic [LVL_W-1:0] max_o
);

   localparam int unsigned NLVL  = 1 << LVL_W;
   localparam int unsigned TH_W  = NLVL - 1;

   generate
      if (USE_THERMO) begin : g_thermo
         logic [TH_W-1:0] th_a;
         logic [TH_W-1:0] th_b;
         logic [TH_W-1:0] th_or;

         for (genvar i = 0; i < TH_W; i++) begin : g_bit
            assign th_a[i] = (a_i > LVL_W'(i));
            assign th_b[i] = (b_i > LVL_W'(i));
         end

         assign th_or = th_a | th_b;

         always_comb begin
            max_o = '0;
            for (int k = 0; k < TH_W; k++) begin
               max_o = max_o + LVL_W'(th_or[k]);
            end
         end
      end else begin : g_cmp
         always_comb begin
            if (a_i >= b_i) max_o = a_i;
            else            max_o = b_i;
         end
      end
   endgenerate

endmodule

// File: rtl/seg_priv_decide.sv
module seg_priv_decide
   import seg_priv_pkg::*;
#(
   parameter int unsigned LVL_W = 2
) (
   input  acc_kind_e        kind_i,
   input  logic [LVL_W-1:0] epl_i,
   input  logic [LVL_W-1:0] cpl_i,
   input  logic [LVL_W-1:0] dpl_i,
   output logic             grant_o,
   output logic             fault_o
);

   logic data_ok;
   logic code_ok;

   assign data_ok = (epl_i <= dpl_i);
   assign code_ok = (dpl_i <= cpl_i);

   always_comb begin
      unique case (kind_i)
         ACC_CODE: grant_o = code_ok;
         default:  grant_o = data_ok;
      endcase
      fault_o = ~grant_o;
   end

endmodule

// File: rtl/seg_priv_check.sv
module seg_priv_check
   import seg_priv_pkg::*;
#(
   parameter int unsigned LVL_W      = 2,
   parameter bit          USE_THERMO = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic             req_valid_i,
   input  logic             real_mode_i,
   input  logic [LVL_W-1:0] cur_lvl_i,
   input  logic [LVL_W-1:0] rpl_i,
   input  logic [LVL_W-1:0] dpl_i,
   input  logic             kind_i,
   output logic [LVL_W-1:0] epl_o,
   output logic             grant_o,
   output logic             fault_o
);

   generate
      if (LVL_W < LVL_W_MIN || LVL_W > LVL_W_MAX) begin : g_bad_width
         $error("seg_priv_check: LVL_W out of supported range");
      end
   endgenerate

   logic [LVL_W-1:0] cpl_c;
   logic [LVL_W-1:0] epl_c;
   logic             grant_c;
   logic             fault_c;
   acc_kind_e        kind_c;

   assign kind_c = acc_kind_e'(kind_i);

   seg_priv_cpl_sel #(.LVL_W(LVL_W)) u_cpl (
      .real_mode_i (real_mode_i),
      .cur_lvl_i   (cur_lvl_i),
      .cpl_o       (cpl_c)
   );

   seg_priv_epl #(.LVL_W(LVL_W), .USE_THERMO(USE_THERMO)) u_epl (
      .a_i   (rpl_i),
      .b_i   (cpl_c),
      .max_o (epl_c)
   );

   seg_priv_decide #(.LVL_W(LVL_W)) u_dec (
      .kind_i  (kind_c),
      .epl_i   (epl_c),
      .cpl_i   (cpl_c),
      .dpl_i   (dpl_i),
      .grant_o (grant_c),
      .fault_o (fault_c)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         grant_o <= 1'b0;
         fault_o <= 1'b0;
         epl_o   <= '0;
      end else if (req_valid_i) begin
         grant_o <= grant_c;
         fault_o <= fault_c;
         epl_o   <= epl_c;
      end else begin
         grant_o <= 1'b0;
         fault_o <= 1'b0;
         epl_o   <= '0;
      end
   end

   assert_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !(grant_o && fault_o));

   assert_answer_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      req_valid_i |=> (grant_o || fault_o));

   assert_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      !req_valid_i |=> (!grant_o && !fault_o && epl_o == '0));

   assert_epl_floor_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      req_valid_i |=> (epl_o >= $past(rpl_i)));

   assert_real_epl_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (req_valid_i && real_mode_i) |=> (epl_o == $past(rpl_i)));

   assert_data_fault_R5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (req_valid_i && !kind_i && rpl_i > dpl_i) |=> fault_o);

   assert_code_fault_R6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (req_valid_i && kind_i && !real_mode_i && dpl_i > cur_lvl_i) |=> fault_o);

endmodule

// File: tb/seg_priv_check_bench.sv
module seg_priv_check_bench;

   localparam int unsigned LVL_W  = 2;
   localparam time         CLK_P  = 10ns;
   localparam int unsigned N_RAND = 3000;

   logic             clk;
   logic             rst_n;
   logic             req_valid;
   logic             real_mode;
   logic [LVL_W-1:0] cur_lvl;
   logic [LVL_W-1:0] rpl;
   logic [LVL_W-1:0] dpl;
   logic             kind;
   logic [LVL_W-1:0] epl;
   logic             grant;
   logic             fault;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   seg_priv_check #(.LVL_W(LVL_W)) u_seg_priv_check (
      .clk_i       (clk),
      .rst_n_i     (rst_n),
      .req_valid_i (req_valid),
      .real_mode_i (real_mode),
      .cur_lvl_i   (cur_lvl),
      .rpl_i       (rpl),
      .dpl_i       (dpl),
      .kind_i      (kind),
      .epl_o       (epl),
      .grant_o     (grant),
      .fault_o     (fault)
   );

   initial clk = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   function automatic int exp_epl(bit rm, int cur, int r);
      int c = rm ? 0 : cur;
      return (r > c) ? r : c;
   endfunction

   function automatic bit exp_grant(bit rm, int cur, int r, int d, bit k);
      int c = rm ? 0 : cur;
      if (k) return (d <= c);
      return (exp_epl(rm, cur, r) <= d);
   endfunction

   task automatic check(bit ok, string req, int act, int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   // drive at a falling edge, check at the next falling edge
   task automatic do_req(bit rm, int cur, int r, int d, bit k, string tag);
      bit g;
      int e;
      req_valid = 1'b1;
      real_mode = rm;
      cur_lvl   = LVL_W'(cur);
      rpl       = LVL_W'(r);
      dpl       = LVL_W'(d);
      kind      = k;
      g = exp_grant(rm, cur, r, d, k);
      e = exp_epl(rm, cur, r);
      @(negedge clk);
      check(epl == LVL_W'(e), {tag, " R3 epl"}, int'(epl), e);
      check(grant == g, {tag, " grant"}, int'(grant), int'(g));
      check(fault == !g, {tag, " R7 fault"}, int'(fault), int'(!g));
   endtask

   task automatic do_idle(int cur, int r, int d, bit k);
      req_valid = 1'b0;
      real_mode = 1'b0;
      cur_lvl   = LVL_W'(cur);
      rpl       = LVL_W'(r);
      dpl       = LVL_W'(d);
      kind      = k;
      @(negedge clk);
      check(grant == 1'b0, "R2 idle grant", int'(grant), 0);
      check(fault == 1'b0, "R2 idle fault", int'(fault), 0);
      check(epl == '0, "R2 idle epl", int'(epl), 0);
   endtask

   initial begin
      #(CLK_P * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      finish_run();
   end

   initial begin
      int unsigned seed_v;
      seed_v    = $urandom(32'd20240611);
      rst_n     = 1'b0;
      req_valid = 1'b1;
      real_mode = 1'b0;
      cur_lvl   = 2'd3;
      rpl       = 2'd3;
      dpl       = 2'd0;
      kind      = 1'b0;
      repeat (3) @(negedge clk);
      check(grant == 1'b0, "R1 reset grant", int'(grant), 0);
      check(fault == 1'b0, "R1 reset fault", int'(fault), 0);
      check(epl == '0, "R1 reset epl", int'(epl), 0);
      req_valid = 1'b0;
      rst_n     = 1'b1;
      @(negedge clk);
      check(grant == 1'b0 && fault == 1'b0 && epl == '0, "R1 post-reset",
            int'({grant, fault}), 0);

      // R3: requested 3 dominates running 0
      do_req(0, 0, 3, 3, 0, "R5 rpl3 dpl3");
      do_req(0, 0, 3, 2, 0, "R5 rpl3 dpl2");
      // R3: requested 0 yields running level
      do_req(0, 2, 0, 2, 0, "R5 cpl2 dpl2");
      do_req(0, 2, 0, 1, 0, "R5 cpl2 dpl1");
      // R4: real mode forces running level to 0
      do_req(1, 3, 1, 1, 0, "R4 real data");
      do_req(1, 3, 0, 0, 1, "R4 real code");
      // R6: code transfers, rpl has no effect
      do_req(0, 3, 0, 0, 1, "R6 code dpl0 cpl3");
      do_req(0, 1, 0, 3, 1, "R6 code dpl3 cpl1");
      do_req(0, 0, 3, 0, 1, "R6 code rpl3 ignored");
      do_req(0, 2, 3, 2, 1, "R6 code equal");
      // R2: idle with inputs that would fault
      do_idle(3, 3, 0, 0);
      do_req(0, 1, 1, 1, 0, "R5 equal");
      do_idle(3, 0, 0, 0);

      for (int i = 0; i < N_RAND; i++) begin
         bit v;
         v = ($urandom % 5) != 0;
         if (v)
            do_req(bit'($urandom % 4 == 0), int'($urandom % 4), int'($urandom % 4),
                   int'($urandom % 4), bit'($urandom % 2), "R5/R6 random");
         else
            do_idle(int'($urandom % 4), int'($urandom % 4), int'($urandom % 4),
                    bit'($urandom % 2));
      end

      finish_run();
   end

endmodule